// File: doc/BRIEF.md
# Two-Tap Averaging Filter with Request/Acknowledge Channels

This block is a streaming filter that averages each new sample with the one before it. Samples come in over a four-phase request/acknowledge channel and results leave over a second four-phase channel. For each accepted sample `x` the filter emits `(x + y) / 2`, where `y` is the previously accepted sample. It then replaces `y` with `x`. Before the first sample, `y` is zero.

Inside, the work runs as a fixed sequence of local steps. First the incoming sample is captured into a holding stage. Then a bundled adder is started, and its completion comes after a matched delay measured in clock cycles. Next the output stage is loaded and offered downstream. The history stage is rewritten only after the consumer has taken the result. Because of this ordering, a stalled consumer can never see a history value that has already moved on to the next sample.

Top module: `avg2_filter`

## Requirements
- R1: After reset, `in_ack` and `out_req` are low, `out_data` is zero, and the history value is zero.
- R2: The first result after reset equals the first sample shifted right by one, because the history starts at zero.
- R3: Each result equals `(x + y) >> 1`, with the sum formed at `W+1` bits so that no carry is lost and the low bit is truncated. After the result is accepted, `y` becomes `x`.
- R4: `in_ack` rises only on a cycle after `in_req` was sampled high. It stays high while `in_req` stays high, and it falls one cycle after `in_req` is seen low.
- R5: A new sample is not accepted while a result is still pending. `in_ack` never rises on the cycle after `out_req` or `out_ack` was high.
- R6: Once raised, `out_req` stays high and `out_data` stays unchanged until `out_ack` is seen high.
- R7: `out_req` falls on the cycle after `out_req` and `out_ack` are both high.
- R8: `out_req` rises exactly `ADD_DLY` clock cycles after the `in_ack` rise that belongs to the same sample. This is the adder's matched delay, which defaults to 2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_req | input | 1 | Producer request: `in_data` is valid |
| in_ack | output | 1 | Sample captured; the producer may change `in_data` |
| in_data | input | W | Input sample |
| out_req | output | 1 | Result is valid on `out_data` |
| out_ack | input | 1 | Consumer has taken the result |
| out_data | output | W | Averaged result |

## Verification
A history stage that was written too early, or not written at all, shows up as a wrong value on the very next result. Each result therefore exposes the state left behind by the sample before it, within one handshake. A broken sequencer shows at the channel pins. It would raise `in_ack` while a result is still pending, let `out_data` move while `out_req` is high, or raise `out_req` at a spacing from `in_ack` other than the matched delay. The bench inserts random stalls on both channels so that each of these orderings is exercised many times.

// File: rtl/avg2_filter.sv
module avg2_filter #(
  parameter int W       = 8,
  parameter int ADD_DLY = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_req,
  output logic         in_ack,
  input  logic [W-1:0] in_data,
  output logic         out_req,
  input  logic         out_ack,
  output logic [W-1:0] out_data
);
  localparam int CW = (ADD_DLY > 1) ? $clog2(ADD_DLY) : 1;

  typedef enum logic [1:0] {S_IDLE, S_ADD, S_OUT, S_RTZ} state_t;

  state_t        st;
  logic [W-1:0]  x_q, y_q;
  logic [CW-1:0] dly;
  logic [W:0]    sum;
  logic          take, add_done;

  assign take     = (st == S_IDLE) && in_req && !in_ack && !out_ack;
  assign sum      = {1'b0, x_q} + {1'b0, y_q};
  assign add_done = (dly == CW'(ADD_DLY - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      x_q      <= '0;
      y_q      <= '0;
      dly      <= '0;
      in_ack   <= 1'b0;
      out_req  <= 1'b0;
      out_data <= '0;
    end else begin
      if (in_ack && !in_req) in_ack <= 1'b0;
      case (st)
        S_IDLE: if (take) begin
          x_q    <= in_data;
          in_ack <= 1'b1;
          dly    <= '0;
          st     <= S_ADD;
        end
        S_ADD: begin
          if (add_done) begin
            out_data <= sum[W:1];
            out_req  <= 1'b1;
            st       <= S_OUT;
          end else begin
            dly <= dly + 1'b1;
          end
        end
        S_OUT: if (out_ack) begin
          out_req <= 1'b0;
          y_q     <= x_q;
          st      <= S_RTZ;
        end
        S_RTZ: if (!out_ack) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/avg2_filter_chk.sv
module avg2_filter_chk #(
  parameter int W       = 8,
  parameter int ADD_DLY = 2
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_req,
  input logic         in_ack,
  input logic         out_req,
  input logic         out_ack,
  input logic [W-1:0] out_data
);
  localparam int DW = $clog2(ADD_DLY + 2) + 1;
  logic [DW-1:0] since_ack;

  always_ff @(posedge clk) begin
    if (!rst_n) since_ack <= '0;
    else if (in_ack && !$past(in_ack)) since_ack <= DW'(1);
    else if (since_ack != '1) since_ack <= since_ack + 1'b1;
  end

  AST_ACK_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_ack) |-> $past(in_req)); // R4
  AST_ACK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ack && in_req) |=> in_ack); // R4
  AST_ACK_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ack && !in_req) |=> !in_ack); // R4
  AST_NO_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_ack) |-> (!$past(out_req) && !$past(out_ack))); // R5
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_req && !out_ack) |=> (out_req && $stable(out_data))); // R6
  AST_OUT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (out_req && out_ack) |=> !out_req); // R7
  AST_ADD_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_req) |-> (since_ack == DW'(ADD_DLY))); // R8
endmodule

bind avg2_filter avg2_filter_chk #(.W(W), .ADD_DLY(ADD_DLY)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_req(in_req), .in_ack(in_ack),
  .out_req(out_req), .out_ack(out_ack), .out_data(out_data)
);

// File: tb/avg2_filter_test.sv
module avg2_filter_test;
  localparam int W = 8;
  localparam int ADD_DLY = 2;

  logic clk = 0, rst_n = 0;
  logic in_req = 0, out_ack = 0;
  logic in_ack, out_req;
  logic [W-1:0] in_data = '0, out_data;

  int total = 0, bad = 0;
  logic [W-1:0] exp_q[$];
  logic [W-1:0] hist = '0;
  int first_done = 0;
  int busy_hold = 0;
  int cyc = 0, ack_cyc = 0;
  logic prev_in_ack = 0, prev_out_req = 0, prev_out_ack = 0;

  always #10 clk = ~clk;

  avg2_filter #(.W(W), .ADD_DLY(ADD_DLY)) uut (.*);

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Channel-level checks sampled away from the clock edge
  always @(negedge clk) if (rst_n) begin
    if (in_ack && !prev_in_ack) begin
      chk(!prev_out_req && !prev_out_ack, "R5 accept while busy", 1, 0);
      ack_cyc = cyc;
    end
    if (out_req && !prev_out_req)
      chk(cyc - ack_cyc == ADD_DLY, "R8 adder delay", cyc - ack_cyc, ADD_DLY);
    prev_in_ack = in_ack; prev_out_req = out_req; prev_out_ack = out_ack;
  end

  task automatic send(input logic [W-1:0] x, input int stall);
    @(negedge clk);
    while (in_ack) @(negedge clk);
    in_data = x;
    in_req = 1;
    exp_q.push_back(W'(({1'b0, x} + {1'b0, hist}) >> 1));
    hist = x;
    while (!in_ack) @(negedge clk);
    repeat (stall) @(negedge clk);
    chk(in_ack == 1, "R4 ack held while req high", in_ack, 1);
    in_req = 0;
    in_data = $urandom;
    @(negedge clk);
    chk(in_ack == 0, "R4 ack released", in_ack, 0);
  endtask

  // Monitor / scoreboard
  initial begin
    logic [W-1:0] seen;
    logic [W-1:0] e;
    forever begin
      @(negedge clk);
      if (rst_n && out_req) begin
        seen = out_data;
        repeat ($urandom_range(0, 4) + busy_hold) @(negedge clk);
        chk(out_req && out_data == seen, "R6 result held", out_data, seen);
        e = exp_q.size() ? exp_q.pop_front() : 'x;
        if (first_done == 0)
          chk(out_data == e, "R2 first result", out_data, e);
        else
          chk(out_data == e, "R3 average", out_data, e);
        first_done++;
        out_ack = 1;
        @(negedge clk);
        chk(out_req == 0, "R7 request released", out_req, 0);
        repeat ($urandom_range(0, 3)) @(negedge clk);
        out_ack = 0;
      end
    end
  end

  initial begin
    #3_000_000;
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(in_ack == 0, "R1 in_ack reset", in_ack, 0);
    chk(out_req == 0, "R1 out_req reset", out_req, 0);
    chk(out_data == 0, "R1 out_data reset", out_data, 0);
    rst_n = 1;
    send(8'd201, 0);   // R2: 100, history zero
    send(8'd255, 1);   // R3: (201+255)>>1 = 228
    send(8'd255, 0);   // R3: carry kept, 255
    send(8'd0, 2);     // R3: truncation, 127
    send(8'd3, 0);     // R3: 1
    busy_hold = 12;    // R5: long consumer stall while producer waits
    send(8'd10, 0);
    send(8'd20, 0);
    send(8'd30, 0);
    busy_hold = 0;
    for (int i = 0; i < 60; i++) send($urandom, $urandom_range(0, 3));
    while (exp_q.size() != 0 || out_req || out_ack) @(negedge clk);
    repeat (5) @(negedge clk);
    chk(first_done == 68, "R3 result count", first_done, 68);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule